// File: doc/BRIEF.md
# Multi-Lane Serial Flash Command Sequencer

This block issues one serial flash command at a time. A command is made of phases in a fixed order: an opcode, zero to four address bytes, an optional mode byte, a number of dummy clocks, then write bytes and read bytes. The opcode phase, the address phase (the mode byte included) and the data phase each have their own lane width of one, two, four or eight data lines. When automatic write-enable is requested for a command that carries write data, the block first sends a separate one-byte write-enable transaction (opcode 0x06). Chip select goes high between that transaction and the command itself.

The host places the command fields on the configuration inputs and pulses `start` while `idle` is high. The block captures the fields at that edge. Write bytes are pulled from a valid/ready byte stream. Read bytes leave on a one-cycle valid strobe. Every cycle with `sclk_en` high is one serial clock period. A separate timing block turns that cycle into the pin-level clock and applies the chip-select spacing. Default opcodes (read 0x03, write 0x02) are provided as package constants for the host.

Top module: `sflash_cmd_seq`

## Requirements
- R1: Lane code 0/1/2/3 selects 1/2/4/8 lanes, so a byte takes 8/4/2/1 serial beats. Bits go most significant first. In a multi-lane beat, lane w-1 carries the most significant bit of the group and lane 0 the least. In single-lane mode data leaves on DQ0 and read data is taken from DQ1. In wider modes lanes DQ[w-1:0] are used both ways.
- R2: The phases of a command run in this order: opcode, address, mode byte, dummy, write data, read data. Address bytes go most significant byte first, and their count is 0 to 4. A zero address, write or read count skips that phase.
- R3: The opcode phase uses `inst_lane`. The address and mode-byte phases use `addr_lane`. The write and read data phases use `data_lane`. Each setting is independent of the others.
- R4: When `mode_en` is set, the mode byte follows the last address byte. Then `dummy_cycles` serial clocks follow with no lane driven. A count of zero inserts no dummy clocks.
- R5: During opcode, address, mode and write beats, `dq_oe` is 0x01 in single-lane mode and the low w bits in w-lane mode. During dummy and read beats, and whenever chip select is high, `dq_oe` is 0.
- R6: If `auto_wren` is set and `wr_count` is nonzero, opcode 0x06 is first sent alone on the `inst_lane` width. Chip select is then high for at least one cycle before the command starts. If `auto_wren` is clear or `wr_count` is zero, no such transaction is sent.
- R7: Each read byte is assembled from its beats per R1. It appears on `rd_data` with `rd_valid` high for one cycle, in the cycle after its last beat.
- R8: A write byte is taken in a cycle where `wr_valid` and `wr_ready` are both high. While the block waits for a byte, chip select stays low and `sclk_en` stays low, and the bytes sent are unaffected by such stalls.
- R9: `idle` is high only when no command is in progress. A `start` pulse while `idle` is low has no effect on the running command.
- R10: `done` is high for exactly one cycle per command, with `cs_n` high, right after the last beat. `irq` is set by `done` and stays set until a cycle with `irq_clr` high. A `done` in the same cycle as `irq_clr` leaves `irq` set.
- R11: `sclk_en` is never high while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a command (taken when idle) |
| opcode | input | 8 | Command opcode |
| inst_lane | input | 2 | Lane code for the opcode phase |
| addr_lane | input | 2 | Lane code for the address and mode phases |
| data_lane | input | 2 | Lane code for the data phases |
| addr_nbytes | input | ABW (3) | Address byte count, 0..ADDR_W/8 |
| addr | input | ADDR_W (32) | Address, right-aligned |
| mode_en | input | 1 | Send the mode byte |
| mode_bits | input | 8 | Mode byte value |
| dummy_cycles | input | DUMMY_W (5) | Number of dummy clocks |
| wr_count | input | CNT_W (16) | Write byte count |
| rd_count | input | CNT_W (16) | Read byte count |
| auto_wren | input | 1 | Prefix write-enable before a write |
| idle | output | 1 | No command in progress |
| wr_valid | input | 1 | Write byte available |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Block is taking a write byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| sclk_en | output | 1 | One serial clock period in this cycle |
| cs_n | output | 1 | Chip select, active low |
| dq_out | output | 8 | Data line outputs |
| dq_oe | output | 8 | Data line output enables |
| dq_in | input | 8 | Data line inputs |
| done | output | 1 | End-of-command pulse |
| irq | output | 1 | Sticky completion flag |
| irq_clr | input | 1 | Clear `irq` |

## Verification
Directed commands cover several cases, each separating one behaviour from its neighbours:
- The default single-lane read and the default write with automatic write-enable separate the one-segment and two-segment chip-select patterns.
- An all-octal command with a mode byte and dummy clocks exposes lane mapping errors at the widest setting.
- A mixed-width command catches a phase that picks up the wrong lane setting.
- An opcode-only command, a write-enable request with no write data, and a start pulse during a busy command check that skipped and ignored items leave the serial stream exactly as the rules predict.

Constrained random commands with random write-stream stalls then vary every field at once. Each captured beat and each read byte is compared against a stream that the bench builds from the lane and phase rules.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants of the serial flash command sequencer.
// Assumes lane codes are two bits wide and a byte is eight bits.
package sfc_pkg;

    typedef enum logic [1:0] {
        LANE_X1 = 2'd0,
        LANE_X2 = 2'd1,
        LANE_X4 = 2'd2,
        LANE_X8 = 2'd3
    } lane_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_WREN,
        PH_GAP,
        PH_INST,
        PH_ADDR,
        PH_MODE,
        PH_DUMMY,
        PH_WLOAD,
        PH_WDATA,
        PH_RDATA,
        PH_END
    } phase_e;

    localparam logic [7:0] OP_WREN      = 8'h06;
    localparam logic [7:0] OP_READ_DEF  = 8'h03;
    localparam logic [7:0] OP_WRITE_DEF = 8'h02;

    // Serial beats needed for one byte at a given lane width.
    function automatic logic [3:0] beats_per_byte(lane_e l);
        return 4'd8 >> l;
    endfunction

endpackage

// File: rtl/sfc_lane_tx.sv
`timescale 1ns/1ps
// Lane serializer: picks the bit group of one byte for the current beat.
// Assumes beat_i is below beats_per_byte(lane_i). The group is MSB first, with the top lane holding the group MSB.
module sfc_lane_tx
    import sfc_pkg::*;
(
    input  logic [7:0] byte_i,
    input  logic [2:0] beat_i,
    input  lane_e      lane_i,
    output logic [7:0] dq_o,
    output logic [7:0] oe_o
);
    logic [7:0] shifted;

    // Shift the byte so the current group sits at the top, then map it to lanes.
    always_comb begin
        dq_o    = '0;
        oe_o    = '0;
        shifted = '0;
        case (lane_i)
            LANE_X1: begin
                shifted = byte_i << beat_i;
                dq_o[0] = shifted[7];
                oe_o    = 8'h01;
            end
            LANE_X2: begin
                shifted   = byte_i << {beat_i[1:0], 1'b0};
                dq_o[1:0] = shifted[7:6];
                oe_o      = 8'h03;
            end
            LANE_X4: begin
                shifted   = byte_i << {beat_i[0], 2'b00};
                dq_o[3:0] = shifted[7:4];
                oe_o      = 8'h0F;
            end
            default: begin
                shifted = byte_i;
                dq_o    = shifted;
                oe_o    = 8'hFF;
            end
        endcase
    end
endmodule

// File: rtl/sfc_lane_rx.sv
`timescale 1ns/1ps
// Lane deserializer: gathers read beats into a byte and strobes it out.
// Assumes first_i marks beat 0 of a byte and last_i its final beat. Single-lane input is taken from DQ1.
module sfc_lane_rx
    import sfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_i,
    input  logic       first_i,
    input  logic       last_i,
    input  lane_e      lane_i,
    input  logic [7:0] dq_i,
    output logic       valid_o,
    output logic [7:0] byte_o
);
    logic [7:0] acc;
    logic [7:0] base;
    logic [7:0] acc_nxt;

    // Append this beat's lanes below the bits gathered so far.
    always_comb begin
        base = first_i ? 8'h00 : acc;
        case (lane_i)
            LANE_X1: acc_nxt = {base[6:0], dq_i[1]};
            LANE_X2: acc_nxt = {base[5:0], dq_i[1:0]};
            LANE_X4: acc_nxt = {base[3:0], dq_i[3:0]};
            default: acc_nxt = dq_i;
        endcase
    end

    // Hold the accumulator and register each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            valid_o <= 1'b0;
            byte_o  <= '0;
        end else begin
            valid_o <= sample_i && last_i;
            if (sample_i) begin
                acc <= acc_nxt;
                if (last_i) begin
                    byte_o <= acc_nxt;
                end
            end
        end
    end
endmodule

// File: rtl/sfc_seq_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: captures a command at start and steps through its phases.
// Assumes one serial beat per cycle with sclk_o high. Outputs depend on the phase register only.
module sfc_seq_fsm
    import sfc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    parameter int DUMMY_W = 5,
    localparam int ABYTES = ADDR_W / 8,
    localparam int ABW    = $clog2(ABYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         opcode,
    input  logic [1:0]         inst_lane,
    input  logic [1:0]         addr_lane,
    input  logic [1:0]         data_lane,
    input  logic [ABW-1:0]     addr_nbytes,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               mode_en,
    input  logic [7:0]         mode_bits,
    input  logic [DUMMY_W-1:0] dummy_cycles,
    input  logic [CNT_W-1:0]   wr_count,
    input  logic [CNT_W-1:0]   rd_count,
    input  logic               auto_wren,
    input  logic               wr_valid,
    input  logic [7:0]         wr_data,
    output logic               wr_ready,
    output logic               idle,
    output logic               sclk_o,
    output logic               cs_n_o,
    output logic               drive_o,
    output logic               rd_sample_o,
    output logic [2:0]         beat_o,
    output logic               last_beat_o,
    output lane_e              lane_o,
    output logic [7:0]         tx_byte_o,
    output logic               done_o
);
    phase_e             ph;
    logic [7:0]         c_op;
    lane_e              c_il;
    lane_e              c_al;
    lane_e              c_dl;
    logic [ABW-1:0]     c_anb;
    logic [ADDR_W-1:0]  c_addr;
    logic               c_men;
    logic [7:0]         c_mbits;
    logic [DUMMY_W-1:0] c_dcyc;
    logic [CNT_W-1:0]   c_wcnt;
    logic [CNT_W-1:0]   c_rcnt;
    logic [2:0]         beat;
    logic [CNT_W-1:0]   bcnt;
    logic [DUMMY_W-1:0] dcnt;
    logic [7:0]         wbuf;

    lane_e              cur_lane;
    logic               last_beat;
    logic               shifting;
    logic [ABW-1:0]     aidx;
    phase_e             ph_data;
    phase_e             ph_after_mode;
    phase_e             ph_after_addr;
    phase_e             ph_after_inst;

    // Lane setting of the phase in progress.
    always_comb begin
        case (ph)
            PH_WREN, PH_INST: cur_lane = c_il;
            PH_ADDR, PH_MODE: cur_lane = c_al;
            default:          cur_lane = c_dl;
        endcase
    end

    // Beat bookkeeping and the byte offered to the serializer.
    always_comb begin
        last_beat = ({1'b0, beat} == (beats_per_byte(cur_lane) - 4'd1));
        aidx      = c_anb - ABW'(1) - bcnt[ABW-1:0];
        case (ph)
            PH_WREN:  tx_byte_o = OP_WREN;
            PH_INST:  tx_byte_o = c_op;
            PH_ADDR:  tx_byte_o = 8'(c_addr >> {aidx, 3'b000});
            PH_MODE:  tx_byte_o = c_mbits;
            PH_WDATA: tx_byte_o = wbuf;
            default:  tx_byte_o = 8'h00;
        endcase
    end

    // Successor phases; a zero count skips its phase.
    always_comb begin
        if (c_wcnt != '0)      ph_data = PH_WLOAD;
        else if (c_rcnt != '0) ph_data = PH_RDATA;
        else                   ph_data = PH_END;
        ph_after_mode = (c_dcyc != '0) ? PH_DUMMY : ph_data;
        ph_after_addr = c_men ? PH_MODE : ph_after_mode;
        ph_after_inst = (c_anb != '0) ? PH_ADDR : ph_after_addr;
    end

    // Moore outputs decoded from the phase register.
    always_comb begin
        shifting    = (ph == PH_WREN) || (ph == PH_INST) || (ph == PH_ADDR) ||
                      (ph == PH_MODE) || (ph == PH_WDATA) || (ph == PH_RDATA);
        drive_o     = shifting && (ph != PH_RDATA);
        sclk_o      = shifting || (ph == PH_DUMMY);
        cs_n_o      = (ph == PH_IDLE) || (ph == PH_GAP) || (ph == PH_END);
        rd_sample_o = (ph == PH_RDATA);
        done_o      = (ph == PH_END);
        wr_ready    = (ph == PH_WLOAD);
        idle        = (ph == PH_IDLE);
        beat_o      = beat;
        last_beat_o = last_beat;
        lane_o      = cur_lane;
    end

    // Phase register, command capture and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_IDLE;
            c_op    <= '0;
            c_il    <= LANE_X1;
            c_al    <= LANE_X1;
            c_dl    <= LANE_X1;
            c_anb   <= '0;
            c_addr  <= '0;
            c_men   <= 1'b0;
            c_mbits <= '0;
            c_dcyc  <= '0;
            c_wcnt  <= '0;
            c_rcnt  <= '0;
            beat    <= '0;
            bcnt    <= '0;
            dcnt    <= '0;
            wbuf    <= '0;
        end else begin
            if (shifting) begin
                beat <= last_beat ? 3'd0 : beat + 3'd1;
            end
            dcnt <= (ph == PH_DUMMY) ? dcnt + DUMMY_W'(1) : '0;
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        c_op    <= opcode;
                        c_il    <= lane_e'(inst_lane);
                        c_al    <= lane_e'(addr_lane);
                        c_dl    <= lane_e'(data_lane);
                        c_anb   <= addr_nbytes;
                        c_addr  <= addr;
                        c_men   <= mode_en;
                        c_mbits <= mode_bits;
                        c_dcyc  <= dummy_cycles;
                        c_wcnt  <= wr_count;
                        c_rcnt  <= rd_count;
                        beat    <= '0;
                        bcnt    <= '0;
                        ph      <= (auto_wren && (wr_count != '0)) ? PH_WREN : PH_INST;
                    end
                end
                PH_WREN: if (last_beat) ph <= PH_GAP;
                PH_GAP:  ph <= PH_INST;
                PH_INST: if (last_beat) ph <= ph_after_inst;
                PH_ADDR: begin
                    if (last_beat) begin
                        if (bcnt == CNT_W'(c_anb) - CNT_W'(1)) begin
                            bcnt <= '0;
                            ph   <= ph_after_addr;
                        end else begin
                            bcnt <= bcnt + CNT_W'(1);
                        end
                    end
                end
                PH_MODE: if (last_beat) ph <= ph_after_mode;
                PH_DUMMY: begin
                    if (dcnt == c_dcyc - DUMMY_W'(1)) ph <= ph_data;
                end
                PH_WLOAD: begin
                    if (wr_valid) begin
                        wbuf <= wr_data;
                        ph   <= PH_WDATA;
                    end
                end
                PH_WDATA: begin
                    if (last_beat) begin
                        if (bcnt == c_wcnt - CNT_W'(1)) begin
                            bcnt <= '0;
                            ph   <= (c_rcnt != '0) ? PH_RDATA : PH_END;
                        end else begin
                            bcnt <= bcnt + CNT_W'(1);
                            ph   <= PH_WLOAD;
                        end
                    end
                end
                PH_RDATA: begin
                    if (last_beat) begin
                        if (bcnt == c_rcnt - CNT_W'(1)) begin
                            bcnt <= '0;
                            ph   <= PH_END;
                        end else begin
                            bcnt <= bcnt + CNT_W'(1);
                        end
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sflash_cmd_seq.sv
`timescale 1ns/1ps
// Top: serial flash command sequencer with per-phase lane widths.
// Assumes the serial clock divider and chip-select spacing live in a separate timing block.
module sflash_cmd_seq
    import sfc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    parameter int DUMMY_W = 5,
    localparam int ABW    = $clog2(ADDR_W / 8 + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         opcode,
    input  logic [1:0]         inst_lane,
    input  logic [1:0]         addr_lane,
    input  logic [1:0]         data_lane,
    input  logic [ABW-1:0]     addr_nbytes,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               mode_en,
    input  logic [7:0]         mode_bits,
    input  logic [DUMMY_W-1:0] dummy_cycles,
    input  logic [CNT_W-1:0]   wr_count,
    input  logic [CNT_W-1:0]   rd_count,
    input  logic               auto_wren,
    output logic               idle,
    input  logic               wr_valid,
    input  logic [7:0]         wr_data,
    output logic               wr_ready,
    output logic               rd_valid,
    output logic [7:0]         rd_data,
    output logic               sclk_en,
    output logic               cs_n,
    output logic [7:0]         dq_out,
    output logic [7:0]         dq_oe,
    input  logic [7:0]         dq_in,
    output logic               done,
    output logic               irq,
    input  logic               irq_clr
);
    logic       drive;
    logic       rd_sample;
    logic [2:0] beat;
    logic       last_beat;
    lane_e      lane;
    logic [7:0] tx_byte;
    logic [7:0] tx_dq;
    logic [7:0] tx_oe;

    sfc_seq_fsm #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .DUMMY_W (DUMMY_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .opcode       (opcode),
        .inst_lane    (inst_lane),
        .addr_lane    (addr_lane),
        .data_lane    (data_lane),
        .addr_nbytes  (addr_nbytes),
        .addr         (addr),
        .mode_en      (mode_en),
        .mode_bits    (mode_bits),
        .dummy_cycles (dummy_cycles),
        .wr_count     (wr_count),
        .rd_count     (rd_count),
        .auto_wren    (auto_wren),
        .wr_valid     (wr_valid),
        .wr_data      (wr_data),
        .wr_ready     (wr_ready),
        .idle         (idle),
        .sclk_o       (sclk_en),
        .cs_n_o       (cs_n),
        .drive_o      (drive),
        .rd_sample_o  (rd_sample),
        .beat_o       (beat),
        .last_beat_o  (last_beat),
        .lane_o       (lane),
        .tx_byte_o    (tx_byte),
        .done_o       (done)
    );

    sfc_lane_tx u_tx (
        .byte_i (tx_byte),
        .beat_i (beat),
        .lane_i (lane),
        .dq_o   (tx_dq),
        .oe_o   (tx_oe)
    );

    sfc_lane_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (rd_sample),
        .first_i  (beat == 3'd0),
        .last_i   (last_beat),
        .lane_i   (lane),
        .dq_i     (dq_in),
        .valid_o  (rd_valid),
        .byte_o   (rd_data)
    );

    // Lines are driven only in phases where the block owns them.
    always_comb begin
        dq_out = drive ? tx_dq : 8'h00;
        dq_oe  = drive ? tx_oe : 8'h00;
    end

    // Sticky completion flag; a new done wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= done || (irq && !irq_clr);
        end
    end
endmodule

// File: rtl/sfc_seq_chk.sv
`timescale 1ns/1ps
// Checker: port-level properties of the sequencer, bound to the top module.
module sfc_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       idle,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       sclk_en,
    input logic       cs_n,
    input logic [7:0] dq_oe,
    input logic       done,
    input logic       irq,
    input logic       irq_clr
);
    AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk_en); // R11

    AST_OE_OFF_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (dq_oe == 8'h00)); // R5

    AST_OE_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        ((dq_oe & (dq_oe + 8'd1)) == 8'h00)); // R5

    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(dq_oe) == 8'h00)); // R5

    AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq); // R10

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (cs_n && !sclk_en)); // R9

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start) |=> !idle); // R9

    AST_WAIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (!cs_n && !sclk_en)); // R8
endmodule

bind sflash_cmd_seq sfc_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .idle     (idle),
    .wr_ready (wr_ready),
    .rd_valid (rd_valid),
    .sclk_en  (sclk_en),
    .cs_n     (cs_n),
    .dq_oe    (dq_oe),
    .done     (done),
    .irq      (irq),
    .irq_clr  (irq_clr)
);

// File: tb/sflash_cmd_seq_bench.sv
`timescale 1ns/1ps
// Bench: directed and seeded random commands, checked beat by beat against a model stream.
module sflash_cmd_seq_bench;
    localparam int ADDR_W = 32;
    localparam int CNT_W = 16;
    localparam int DUMMY_W = 5;
    localparam int ABW = 3;
    localparam int MAXB = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] opcode = 8'h03;
    logic [1:0] inst_lane = 2'd0, addr_lane = 2'd0, data_lane = 2'd0;
    logic [ABW-1:0] addr_nbytes = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic mode_en = 1'b0;
    logic [7:0] mode_bits = 8'h00;
    logic [DUMMY_W-1:0] dummy_cycles = '0;
    logic [CNT_W-1:0] wr_count = '0, rd_count = '0;
    logic auto_wren = 1'b0;
    logic idle, wr_ready, rd_valid, sclk_en, cs_n, done, irq;
    logic wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data, dq_out, dq_oe;
    logic [7:0] dq_in = 8'h00;
    logic irq_clr = 1'b0;

    sflash_cmd_seq u_sflash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .inst_lane(inst_lane), .addr_lane(addr_lane), .data_lane(data_lane),
        .addr_nbytes(addr_nbytes), .addr(addr), .mode_en(mode_en), .mode_bits(mode_bits),
        .dummy_cycles(dummy_cycles), .wr_count(wr_count), .rd_count(rd_count),
        .auto_wren(auto_wren), .idle(idle), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data), .sclk_en(sclk_en),
        .cs_n(cs_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .done(done),
        .irq(irq), .irq_clr(irq_clr)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // captured activity
    logic [7:0] c_out [MAXB];
    logic [7:0] c_oe  [MAXB];
    int         c_seg [MAXB];
    logic [7:0] c_rd  [64];
    int nc = 0, nr = 0, seg = 0, spos = 0, ndone = 0;
    bit was_low = 0;
    // expected activity
    logic [7:0] e_out [MAXB];
    logic [7:0] e_oe  [MAXB];
    int         e_seg [MAXB];
    logic [7:0] e_rd  [64];
    int ne = 0, ner = 0, e_s = 0, e_pos = 0;
    // write stream
    logic [7:0] wbytes [64];
    int wn = 0, wi = 0;
    bit hs_pend = 0;
    bit stall_en = 0;

    function automatic logic [7:0] dqh(int i);
        return 8'(i * 29 + 90) ^ 8'(i >> 3);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Device side: record beats, feed read lanes, drive the write stream.
    always @(negedge clk) begin
        if (!cs_n) begin
            if (sclk_en) begin
                if (nc < MAXB) begin
                    c_out[nc] = dq_out; c_oe[nc] = dq_oe; c_seg[nc] = seg;
                end
                nc++;
                dq_in = dqh(spos);
                spos++;
            end
        end else begin
            if (was_low) seg++;
            spos = 0;
        end
        was_low = !cs_n;
        if (rd_valid) begin
            if (nr < 64) c_rd[nr] = rd_data;
            nr++;
        end
        if (done) ndone++;
        if (hs_pend) wi++;
        wr_data  = (wi < wn) ? wbytes[wi] : 8'h00;
        wr_valid = (wi < wn) && (!stall_en || ($urandom % 3 != 0));
        hs_pend  = wr_valid && wr_ready;
    end

    task automatic push_beat(logic [7:0] o, logic [7:0] oe);
        e_out[ne] = o; e_oe[ne] = oe; e_seg[ne] = e_s; ne++; e_pos++;
    endtask

    task automatic push_byte(logic [7:0] b, logic [1:0] l);
        int w = 1 << l;
        for (int bt = 0; bt < (8 >> l); bt++) begin
            logic [7:0] o = 8'h00;
            for (int i = 0; i < w; i++) o[i] = b[8 - (bt + 1) * w + i];
            push_beat(o, (l == 2'd0) ? 8'h01 : 8'((1 << w) - 1));
        end
    endtask

    task automatic push_read(logic [1:0] l);
        int w = 1 << l;
        logic [7:0] acc = 8'h00;
        for (int bt = 0; bt < (8 >> l); bt++) begin
            logic [7:0] d = dqh(e_pos);
            if (l == 2'd0) acc = {acc[6:0], d[1]};
            else for (int i = w - 1; i >= 0; i--) acc = {acc[6:0], d[i]};
            push_beat(8'h00, 8'h00);
        end
        e_rd[ner] = acc; ner++;
    endtask

    // Build the expected stream from the current command inputs.
    task automatic build_expected();
        ne = 0; ner = 0; e_s = 0; e_pos = 0;
        if (auto_wren && wr_count != 0) begin
            push_byte(8'h06, inst_lane);
            e_s = 1; e_pos = 0;
        end
        push_byte(opcode, inst_lane);
        for (int k = 0; k < int'(addr_nbytes); k++)
            push_byte(addr[(int'(addr_nbytes) - 1 - k) * 8 +: 8], addr_lane);
        if (mode_en) push_byte(mode_bits, addr_lane);
        for (int k = 0; k < int'(dummy_cycles); k++) push_beat(8'h00, 8'h00);
        for (int k = 0; k < int'(wr_count); k++) push_byte(wbytes[k], data_lane);
        for (int k = 0; k < int'(rd_count); k++) push_read(data_lane);
    endtask

    task automatic exec(string tag, bit poke);
        int t;
        int bad;
        build_expected();
        @(posedge clk);
        nc = 0; nr = 0; seg = 0; ndone = 0; wi = 0; wn = int'(wr_count);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(idle == 1'b0, "R9", {tag, " idle low while busy"}, int'(idle), 0);
        if (poke) begin
            logic [7:0] save_op = opcode;
            repeat (4) @(negedge clk);
            opcode = 8'hA5; start = 1'b1;
            @(negedge clk); start = 1'b0; opcode = save_op;
        end
        t = 0;
        while (ndone == 0 && t < 3000) begin @(posedge clk); t++; end
        chk(ndone > 0, "R10", {tag, " command completes"}, ndone, 1);
        repeat (3) @(negedge clk);
        chk(nc == ne, "R2", {tag, " beat count"}, nc, ne);
        bad = -1;
        for (int i = 0; i < ne && i < nc; i++)
            if (bad < 0 && (((c_out[i] & c_oe[i]) != (e_out[i] & e_oe[i])) ||
                            (c_oe[i] != e_oe[i]) || (c_seg[i] != e_seg[i]))) bad = i;
        if (bad >= 0)
            chk(0, "R1 R3 R4 R5 R6", {tag, " beat content (out,oe)"},
                {c_seg[bad], c_oe[bad], c_out[bad]}, {e_seg[bad], e_oe[bad], e_out[bad]});
        else
            chk(1, "R1", tag, 0, 0);
        chk(seg == e_s + 1, "R6", {tag, " chip-select segments"}, seg, e_s + 1);
        chk(nr == ner, "R7", {tag, " read byte count"}, nr, ner);
        bad = -1;
        for (int i = 0; i < ner && i < nr; i++) if (bad < 0 && c_rd[i] != e_rd[i]) bad = i;
        if (bad >= 0) chk(0, "R7", {tag, " read byte"}, c_rd[bad], e_rd[bad]);
        chk(wi == wn, "R8", {tag, " write bytes taken"}, wi, wn);
        chk(ndone == 1 && idle && irq, "R10", {tag, " done once, idle, irq set"},
            {ndone, 1'(idle), 1'(irq)}, {32'd1, 1'b1, 1'b1});
        irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        chk(irq == 1'b0, "R10", {tag, " irq cleared"}, int'(irq), 0);
    endtask

    task automatic set_cmd(logic [7:0] op, logic [1:0] il, logic [1:0] al, logic [1:0] dl,
                           int anb, logic [31:0] a, bit men, logic [7:0] mb, int dc,
                           int wc, int rc, bit aw);
        opcode = op; inst_lane = il; addr_lane = al; data_lane = dl;
        addr_nbytes = ABW'(anb); addr = a; mode_en = men; mode_bits = mb;
        dummy_cycles = DUMMY_W'(dc); wr_count = CNT_W'(wc); rd_count = CNT_W'(rc);
        auto_wren = aw;
        for (int k = 0; k < 64; k++) wbytes[k] = 8'($urandom);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(idle && cs_n && !sclk_en && dq_oe == 0 && !irq && !rd_valid && !done,
            "R9 R11", "reset outputs", {1'(idle), 1'(cs_n), 1'(sclk_en), 1'(irq)},
            {1'b1, 1'b1, 1'b0, 1'b0});
        // default read, single lane
        set_cmd(8'h03, 0, 0, 0, 3, 32'h00123456, 0, 0, 0, 0, 4, 0);
        exec("default read R1 R2", 0);
        // default write with write-enable prefix
        set_cmd(8'h02, 0, 0, 0, 3, 32'h00ABCDEF, 0, 0, 0, 4, 0, 1);
        exec("write with prefix R6", 0);
        // all octal, mode byte, dummy clocks
        set_cmd(8'hEC, 3, 3, 3, 4, 32'hDEADBEEF, 1, 8'hA0, 8, 0, 6, 0);
        exec("octal mode dummy R3 R4", 0);
        // mixed widths
        set_cmd(8'hEB, 0, 2, 1, 3, 32'h00F0E1D2, 1, 8'h5C, 0, 0, 3, 0);
        exec("mixed lanes R3", 0);
        // opcode only
        set_cmd(8'h66, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        exec("opcode only R2 R6", 0);
        // write-enable flag with no write data, quad opcode
        set_cmd(8'h35, 2, 0, 0, 1, 32'h7E, 0, 0, 2, 0, 2, 1);
        exec("no prefix without write R6", 0);
        // start while busy is ignored
        set_cmd(8'h0B, 0, 0, 0, 3, 32'h00010203, 0, 0, 8, 0, 2, 0);
        exec("start while busy R9", 1);
        // write then read, with stream stalls
        stall_en = 1;
        set_cmd(8'h42, 1, 1, 2, 2, 32'h0000BEEF, 0, 0, 1, 5, 3, 1);
        exec("stalled write R8", 0);
        // seeded random commands
        for (int n = 0; n < 40; n++) begin
            set_cmd(8'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
                    int'($urandom % 5), $urandom, 1'($urandom), 8'($urandom),
                    int'($urandom % 13), int'($urandom % 7), int'($urandom % 7),
                    1'($urandom));
            exec("random R1 R2 R3 R4 R5 R7 R8", 0);
        end
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        #3000000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog R10: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule